// File: doc/BRIEF.md
# Integer Reciprocal Probability Normalizer

This block turns a row of non-negative integer scores into integer-scaled probabilities without floating point. At the start of each row it accepts the row total Z together with the row's configuration. It forms one reciprocal scale factor from Z, then multiplies every score of the row by that single factor as the scores stream through.

Two output formats are offered. The wide format targets a full scale of 32767 and emits 16-bit results. The narrow format targets 255: its reciprocal is pre-multiplied by 2^15 to keep fractional precision, and each product is shifted right by 15 plus a programmable extra shift to yield an unsigned byte. The reciprocal comes either from an exact truncating integer divide, which takes a multi-cycle sequential divider, or from a fast estimate that shifts the target scale right by the position of the leading one of Z. A row total outside the legal band of 256 to 32767 is clamped to the nearer limit and reported on an error flag.

Top module: `rcp_norm`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `sum_ready_o` is 1 and `score_ready_o`, `prob_valid_o` and `err_o` are 0.
- R2: A row total is taken only when `sum_valid_i` and `sum_ready_o` are both 1. That transfer also captures `narrow_i`, `approx_i` and `out_shift_i` for the row. `sum_ready_o` and `score_ready_o` are never 1 together. In exact mode `score_ready_o` stays 0 until the divide has finished.
- R3: In wide mode (`narrow_i`=0) with exact method (`approx_i`=0), the scale is rho = floor(32767 / Z). Each output is s·rho, saturated to 65535.
- R4: In narrow mode (`narrow_i`=1) with exact method, the scale is rho = floor(255·2^15 / Z). Each output is (s·rho) >> (15 + `out_shift_i`), saturated to 255, and bits 15:8 of `prob_o` are 0.
- R5: In approximate mode (`approx_i`=1), k is the bit index of the most significant 1 in Z. rho = Tn >> k, where Tn is 32767 in wide mode and 255·2^15 in narrow mode. The outputs are then formed exactly as in R3 or R4.
- R6: A total below 256 is replaced by 256, and a total above 32767 is replaced by 32767, before the scale is formed. `err_o` goes to 1 when such a total is taken. It goes back to 0 when an in-band total is taken, and changes at no other time.
- R7: While scores are accepted, the scale in use lies between 1 and 32767.
- R8: Each accepted score gives exactly one result, with `prob_valid_o` high in the following cycle. `prob_last_o` repeats `score_last_i`. After the last score of a row, the block takes a new total.
- R9: Changes to `narrow_i`, `approx_i` or `out_shift_i` after the total is taken have no effect on that row's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| narrow_i | input | 1 | 1 selects the byte output format, 0 the 16-bit format |
| approx_i | input | 1 | 1 selects the leading-one reciprocal estimate |
| out_shift_i | input | 4 | Extra right shift in the byte format |
| sum_valid_i | input | 1 | Row total available |
| sum_i | input | 32 | Row total Z |
| sum_ready_o | output | 1 | Block can take a row total |
| score_valid_i | input | 1 | Score available |
| score_i | input | 16 | Non-negative score |
| score_last_i | input | 1 | Marks the final score of the row |
| score_ready_o | output | 1 | Block can take a score |
| prob_valid_o | output | 1 | Result valid |
| prob_o | output | 16 | Scaled probability |
| prob_last_o | output | 1 | Result belongs to the final score of the row |
| err_o | output | 1 | Current row total was outside the legal band |

## Verification
The assertions take for granted that the source holds `sum_valid_i` and `score_valid_i` with steady data until accepted. They also assume every row ends with a score marked last, and that scores are not offered before the row total. The stimulus drives all inputs only at falling edges and waits for the matching ready before moving on. It keeps score valid asserted during the divide so that backpressure is exercised. Row totals are chosen both inside the band and on both sides of it, and a few oversized scores are included to reach the saturation limits.

// File: rtl/rcp_norm_pkg.sv
package rcp_norm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_RUN  = 2'd2
  } norm_st_e;

  localparam int DEF_SCORE_W = 16;
  localparam int DEF_SUM_W   = 32;
  localparam int DEF_OSH_W   = 4;
  localparam int DEF_PRE_SH  = 15;
  localparam int DEF_Z_MIN   = 256;
  localparam int DEF_Z_MAX   = 32767;
  localparam int DEF_T_WIDE  = 32767;
  localparam int DEF_T_NARR  = 255;
  localparam int DEF_NARR_W  = 8;
endpackage

// File: rtl/rcp_msb.sv
module rcp_msb #(
  parameter int W   = 15,
  parameter int K_W = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  output logic [K_W-1:0] idx_o
);
  // highest set bit wins; zero input yields 0
  always_comb begin
    idx_o = '0;
    for (int b = 0; b < W; b++) begin
      if (val_i[b]) idx_o = K_W'(b);
    end
  end
endmodule

// File: rtl/rcp_div.sv
module rcp_div #(
  parameter int DVD_W = 23,
  parameter int DVS_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q, dvs_q;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DVS_W:0]   rem_sh, rem_nx;
  logic             ge;

  always_comb begin
    rem_sh = {rem_q, quo_q[DVD_W-1]};
    ge     = rem_sh >= {1'b0, dvs_q};
    rem_nx = ge ? rem_sh - {1'b0, dvs_q} : rem_sh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= '0;
        dvs_q  <= divisor_i;
        quo_q  <= dividend_i;
        cnt_q  <= CNT_W'(DVD_W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= rem_nx[DVS_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;
endmodule

// File: rtl/rcp_scale.sv
module rcp_scale #(
  parameter int SCORE_W = 16,
  parameter int RHO_W   = 16,
  parameter int OSH_W   = 4,
  parameter int PRE_SH  = 15,
  parameter int NARR_W  = 8
) (
  input  logic [SCORE_W-1:0] score_i,
  input  logic [RHO_W-1:0]   rho_i,
  input  logic               narrow_i,
  input  logic [OSH_W-1:0]   osh_i,
  output logic [SCORE_W-1:0] prob_o
);
  localparam int PROD_W = SCORE_W + RHO_W;
  localparam int SH_W   = $clog2(PRE_SH + (1 << OSH_W));

  logic [PROD_W-1:0] prod, shd;
  logic [SH_W-1:0]   sh;

  always_comb begin
    prod = PROD_W'(score_i) * PROD_W'(rho_i);
    sh   = SH_W'(PRE_SH) + SH_W'(osh_i);
    shd  = prod >> sh;
    if (narrow_i) begin
      if (|shd[PROD_W-1:NARR_W]) prob_o = SCORE_W'({NARR_W{1'b1}});
      else                       prob_o = SCORE_W'(shd[NARR_W-1:0]);
    end else begin
      if (|prod[PROD_W-1:SCORE_W]) prob_o = '1;
      else                         prob_o = prod[SCORE_W-1:0];
    end
  end
endmodule

// File: rtl/rcp_norm.sv
module rcp_norm
  import rcp_norm_pkg::*;
#(
  parameter int SCORE_W = DEF_SCORE_W,
  parameter int SUM_W   = DEF_SUM_W,
  parameter int OSH_W   = DEF_OSH_W,
  parameter int PRE_SH  = DEF_PRE_SH,
  parameter int Z_MIN   = DEF_Z_MIN,
  parameter int Z_MAX   = DEF_Z_MAX,
  parameter int T_WIDE  = DEF_T_WIDE,
  parameter int T_NARR  = DEF_T_NARR,
  parameter int NARR_W  = DEF_NARR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               narrow_i,
  input  logic               approx_i,
  input  logic [OSH_W-1:0]   out_shift_i,
  input  logic               sum_valid_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic               sum_ready_o,
  input  logic               score_valid_i,
  input  logic [SCORE_W-1:0] score_i,
  input  logic               score_last_i,
  output logic               score_ready_o,
  output logic               prob_valid_o,
  output logic [SCORE_W-1:0] prob_o,
  output logic               prob_last_o,
  output logic               err_o
);
  localparam int     ZC_W    = $clog2(Z_MAX + 1);
  localparam int     K_W     = $clog2(ZC_W);
  localparam longint T_NS    = longint'(T_NARR) << PRE_SH;
  localparam int     DVD_W   = $clog2(T_NS + 1);
  localparam int     RHO_W   = SCORE_W;
  localparam int     RHO_MAX = (1 << (RHO_W - 1)) - 1;

  norm_st_e           st_q;
  logic [RHO_W-1:0]   rho_q;
  logic               narrow_q, err_q;
  logic [OSH_W-1:0]   osh_q;
  logic [ZC_W-1:0]    z_clamp;
  logic               z_oob;
  logic [K_W-1:0]     k_idx;
  logic [DVD_W-1:0]   t_sel, t_est, quot;
  logic               div_done, sum_hs, score_hs;
  logic [SCORE_W-1:0] prob_d;

  function automatic logic [RHO_W-1:0] rho_sat(input logic [DVD_W-1:0] v);
    if (v > DVD_W'(RHO_MAX)) return RHO_W'(RHO_MAX);
    else if (v == '0)        return RHO_W'(1);
    else                     return v[RHO_W-1:0];
  endfunction

  assign sum_ready_o   = (st_q == ST_IDLE);
  assign score_ready_o = (st_q == ST_RUN);
  assign sum_hs        = sum_valid_i && sum_ready_o;
  assign score_hs      = score_valid_i && score_ready_o;

  always_comb begin
    z_oob   = 1'b1;
    z_clamp = ZC_W'(Z_MIN);
    if (sum_i > SUM_W'(Z_MAX)) begin
      z_clamp = ZC_W'(Z_MAX);
    end else if (sum_i >= SUM_W'(Z_MIN)) begin
      z_clamp = sum_i[ZC_W-1:0];
      z_oob   = 1'b0;
    end
  end

  assign t_sel = narrow_i ? DVD_W'(T_NS) : DVD_W'(T_WIDE);
  assign t_est = t_sel >> k_idx;

  rcp_msb #(.W(ZC_W), .K_W(K_W)) u_msb (
    .val_i (z_clamp),
    .idx_o (k_idx)
  );

  rcp_div #(.DVD_W(DVD_W), .DVS_W(ZC_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (sum_hs && !approx_i),
    .dividend_i (t_sel),
    .divisor_i  (z_clamp),
    .done_o     (div_done),
    .quot_o     (quot)
  );

  rcp_scale #(
    .SCORE_W (SCORE_W),
    .RHO_W   (RHO_W),
    .OSH_W   (OSH_W),
    .PRE_SH  (PRE_SH),
    .NARR_W  (NARR_W)
  ) u_scale (
    .score_i  (score_i),
    .rho_i    (rho_q),
    .narrow_i (narrow_q),
    .osh_i    (osh_q),
    .prob_o   (prob_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      rho_q        <= RHO_W'(1);
      narrow_q     <= 1'b0;
      osh_q        <= '0;
      err_q        <= 1'b0;
      prob_valid_o <= 1'b0;
      prob_o       <= '0;
      prob_last_o  <= 1'b0;
    end else begin
      prob_valid_o <= score_hs;
      unique case (st_q)
        ST_IDLE: if (sum_hs) begin
          narrow_q <= narrow_i;
          osh_q    <= out_shift_i;
          err_q    <= z_oob;
          if (approx_i) begin
            rho_q <= rho_sat(t_est);
            st_q  <= ST_RUN;
          end else begin
            st_q  <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          rho_q <= rho_sat(quot);
          st_q  <= ST_RUN;
        end
        ST_RUN: if (score_hs) begin
          prob_o      <= prob_d;
          prob_last_o <= score_last_i;
          if (score_last_i) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/rcp_norm_chk.sv
module rcp_norm_chk #(
  parameter int SCORE_W = 16,
  parameter int RHO_W   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sum_valid_i,
  input logic               sum_ready_o,
  input logic               score_valid_i,
  input logic               score_ready_o,
  input logic               prob_valid_o,
  input logic [SCORE_W-1:0] prob_o,
  input logic               err_o,
  input logic [RHO_W-1:0]   rho_q,
  input logic               narrow_q
);
  // R2: total and score channels are never open together
  a_r2_ready_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sum_ready_o && score_ready_o));

  // R8: a result only follows an accepted score
  a_r8_one_per_score: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prob_valid_o |-> $past(score_valid_i && score_ready_o));

  // R7: scale stays within the multiplier operand range
  a_r7_rho_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_ready_o |-> (rho_q >= RHO_W'(1)) && (rho_q <= RHO_W'(32767)));

  // R4: byte format never drives the upper bits
  a_r4_byte_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prob_valid_o && narrow_q) |-> (prob_o[SCORE_W-1:8] == '0));

  // R6: error flag moves only on a total transfer
  a_r6_err_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sum_valid_i && sum_ready_o) |-> $stable(err_o));
endmodule

bind rcp_norm rcp_norm_chk #(.SCORE_W(SCORE_W), .RHO_W(RHO_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sum_valid_i   (sum_valid_i),
  .sum_ready_o   (sum_ready_o),
  .score_valid_i (score_valid_i),
  .score_ready_o (score_ready_o),
  .prob_valid_o  (prob_valid_o),
  .prob_o        (prob_o),
  .err_o         (err_o),
  .rho_q         (rho_q),
  .narrow_q      (narrow_q)
);

// File: tb/rcp_norm_test.sv
module rcp_norm_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        narrow_i = 1'b0, approx_i = 1'b0;
  logic [3:0]  out_shift_i = '0;
  logic        sum_valid_i = 1'b0;
  logic [31:0] sum_i = '0;
  logic        sum_ready_o;
  logic        score_valid_i = 1'b0;
  logic [15:0] score_i = '0;
  logic        score_last_i = 1'b0;
  logic        score_ready_o, prob_valid_o, prob_last_o, err_o;
  logic [15:0] prob_o;

  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  bit          last_q[$];
  int          tag_q[$];

  always #5 clk_i = ~clk_i;

  rcp_norm uut (
    .clk_i, .rst_ni, .narrow_i, .approx_i, .out_shift_i,
    .sum_valid_i, .sum_i, .sum_ready_o,
    .score_valid_i, .score_i, .score_last_i, .score_ready_o,
    .prob_valid_o, .prob_o, .prob_last_o, .err_o
  );

  task automatic chk(input int req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ref_rho(input bit m8, input bit ap, input longint z);
    longint zc, t, k;
    zc = (z < 256) ? 256 : (z > 32767) ? 32767 : z;
    t  = m8 ? 255 * 32768 : 32767;
    if (ap) begin
      k = 0;
      for (int b = 0; b < 15; b++) if (zc[b]) k = b;
      return t >> k;
    end
    return t / zc;
  endfunction

  function automatic longint ref_prob(input bit m8, input int sh, input longint s, input longint rho);
    longint p;
    p = s * rho;
    if (m8) begin
      p = p >> (15 + sh);
      return (p > 255) ? 255 : p;
    end
    return (p > 65535) ? 65535 : p;
  endfunction

  // driver: one full row
  task automatic run_row(input bit m8, input bit ap, input int sh, input longint z,
                         input int n, input int seed, input bit flip, input int tag,
                         input int big);
    longint rho, s;
    bit oob;
    rho = ref_rho(m8, ap, z);
    oob = (z < 256) || (z > 32767);
    narrow_i = m8; approx_i = ap; out_shift_i = 4'(sh);
    sum_i = 32'(z); sum_valid_i = 1'b1;
    while (!sum_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    sum_valid_i = 1'b0;
    chk(6, err_o, oob, "err flag");                    // R6
    if (!ap) chk(2, score_ready_o, 0, "held during divide"); // R2
    if (flip) begin                                      // R9
      narrow_i = ~m8; approx_i = ~ap; out_shift_i = ~4'(sh);
    end
    for (int i = 0; i < n; i++) begin
      s = (i == 0 && big != 0) ? big : (seed * 53 + i * 211) % 997;
      score_i = 16'(s); score_last_i = (i == n - 1); score_valid_i = 1'b1;
      while (!score_ready_o) @(negedge clk_i);
      exp_q.push_back(16'(ref_prob(m8, sh, s, rho)));
      last_q.push_back(i == n - 1);
      tag_q.push_back(tag);
      @(negedge clk_i);
    end
    score_valid_i = 1'b0; score_last_i = 1'b0;
    chk(8, sum_ready_o, 1, "ready for next total");    // R8
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && prob_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected result: actual=%0d expected=none", prob_o);
      end else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic bit l = last_q.pop_front();
        automatic int t = tag_q.pop_front();
        chk(t, prob_o, e, "probability");
        chk(8, prob_last_o, l, "last marker");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(1, sum_ready_o, 1, "sum ready in reset");
    chk(1, score_ready_o, 0, "score ready in reset");
    chk(1, prob_valid_o, 0, "valid in reset");
    chk(1, err_o, 0, "err in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1, sum_ready_o, 1, "sum ready after reset");
    chk(1, prob_valid_o, 0, "valid after reset");
    // R3 wide exact
    run_row(0, 0, 0, 1000, 6, 1, 0, 3, 0);
    run_row(0, 0, 0, 32767, 4, 2, 0, 3, 0);
    // R4 narrow exact, two shifts and lower band edge
    run_row(1, 0, 0, 3000, 6, 3, 0, 4, 0);
    run_row(1, 0, 2, 3000, 5, 4, 0, 4, 0);
    run_row(1, 0, 0, 256, 4, 5, 0, 4, 0);
    // R5 estimate, both formats
    run_row(0, 1, 0, 1000, 5, 6, 0, 5, 0);
    run_row(1, 1, 0, 5000, 5, 7, 0, 5, 0);
    run_row(1, 1, 1, 32767, 3, 8, 0, 5, 0);
    // R6 out-of-band totals, incl. zero
    run_row(0, 0, 0, 100, 4, 9, 0, 6, 0);
    run_row(0, 0, 0, 0, 3, 10, 0, 6, 0);
    run_row(1, 0, 0, 70000, 4, 11, 0, 6, 0);
    run_row(0, 1, 0, 40000, 3, 12, 0, 6, 0);
    // R7 scale extremes with saturation: rho=127, s=60000; rho=32640 byte path
    run_row(0, 0, 0, 256, 3, 13, 0, 7, 60000);
    run_row(1, 0, 0, 256, 3, 14, 0, 7, 60000);
    // R9 configuration moved mid-row
    run_row(1, 0, 1, 2000, 5, 15, 1, 9, 0);
    run_row(0, 1, 0, 700, 5, 16, 1, 9, 0);
    repeat (3) @(negedge clk_i);
    chk(8, exp_q.size(), 0, "all results delivered");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule